// File: doc/BRIEF.md
# Reset Sequencer with Source Identification

This block collects every reset request on the chip (power-on, low-voltage, a watchdog timeout, a clock-monitor failure and a low level on the shared board reset line) and turns them into one ordered reset sequence. Any internal request forces the chip into reset at once, without waiting for a clock edge. The block then pulls the open-drain reset line low for a fixed number of system clock cycles and lets it go. After a settling wait it reads the line back.

The value read back tells the block whether something outside is still holding the line low. That reading, together with two sticky flags that remember clock-monitor and watchdog events, selects the class of reset vector the processor should fetch. When the read is taken, the internal reset is released. A one-cycle strobe is raised, and a 2-bit vector class is presented and held until the next sequence.

The watchdog and clock-monitor counters and the analog detectors sit outside this block. It sees only their request lines and the enable bits that qualify them.

Top module: `rstseq_top`

## Requirements
- R1: A high on `por_req` or `lvr_req`, or a qualified clock-monitor or watchdog request, sets `rst_pin_pd` high and `core_rst_n` low immediately, with no clock edge needed, and holds them there while the request stays high.
- R2: `cm_fail` has an effect only when `cm_en` is 1 and `selfclk_en` is 0. Otherwise `rst_pin_pd` stays low and `core_rst_n` stays high.
- R3: `wdt_timeout` has an effect only when `wdt_rate` is nonzero. With `wdt_rate` equal to 0 the outputs do not change.
- R4: Once the last request has fallen, `rst_pin_pd` stays high for exactly 132 rising clock edges. This is 128 drive cycles plus 2 synchronizer stages plus 2 pipeline stages. The count starts at the first edge after the request falls, and `rst_pin_pd` is low after the 132nd edge.
- R5: After `rst_pin_pd` falls, `core_rst_n` rises after exactly 64 more rising edges. In that same cycle `seq_done` is high, and it is high for that one cycle only.
- R6: If the reset line reads low at the sample, `vec_code` is 2'b00, whatever flags are pending.
- R7: If the line reads high and a clock-monitor event is pending, `vec_code` is 2'b01, even if a watchdog event is also pending.
- R8: If the line reads high with only a watchdog event pending, `vec_code` is 2'b10. With nothing pending it is 2'b00. The code 2'b11 never appears.
- R9: The pending flags survive later reset sequences of any kind except power-on and low-voltage, which clear them. A high on `vec_ack` clears them only while `core_rst_n` is high. A high on `vec_ack` during a sequence has no effect.
- R10: While `core_rst_n` is high, a low on `rst_pin_in` passes through a 2-flop synchronizer. `rst_pin_pd` is still low after the 2nd rising edge and is high after the 3rd, counted from the fall. From that 3rd edge the 132-edge drive of R4 applies.
- R11: `vec_code` stays stable while `core_rst_n` is high and until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on detect, active high |
| lvr_req | input | 1 | Low-voltage detect, active high |
| cm_fail | input | 1 | Clock-monitor failure request |
| cm_en | input | 1 | Clock monitoring enabled |
| selfclk_en | input | 1 | Self-clock fallback enabled (blocks monitor reset) |
| wdt_timeout | input | 1 | Watchdog timeout request |
| wdt_rate | input | 3 | Watchdog rate field; zero disables the watchdog reset |
| rst_pin_in | input | 1 | Level read from the board reset line |
| vec_ack | input | 1 | Vector class consumed; clears pending flags |
| rst_pin_pd | output | 1 | Pull-down enable for the open-drain reset line |
| core_rst_n | output | 1 | Internal reset, active low |
| seq_done | output | 1 | One-cycle strobe when the vector class is valid |
| vec_code | output | 2 | Vector class: 00 boot/external, 01 clock monitor, 10 watchdog |

## Verification
A wrong drive or settle counter shows up as the edge count of R4 or R5 being off by one or more. That error is visible on `rst_pin_pd` or `core_rst_n` within about 200 cycles of the request. A pending flag that is lost, or that clears at the wrong time, shows up only in the `vec_code` of the next completed sequence, so the tests chain sequences back to back. A broken synchronizer or restart path for the reset line shifts the entry edge of R10 or the drive length that follows it.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    VEC_BOOT   = 2'b00,
    VEC_CLKMON = 2'b01,
    VEC_WDOG   = 2'b10
  } vec_t;

  typedef enum logic [1:0] {
    ST_DRIVE  = 2'b00,
    ST_SETTLE = 2'b01,
    ST_RUN    = 2'b10
  } seq_st_t;

  function automatic vec_t pick_vec(input logic line_hi, input logic cm_p, input logic wd_p);
    if (!line_hi)  return VEC_BOOT;
    else if (cm_p) return VEC_CLKMON;
    else if (wd_p) return VEC_WDOG;
    else           return VEC_BOOT;
  endfunction
endpackage

// File: rtl/rstseq_req.sv
module rstseq_req #(
  parameter int RATE_W = 3
) (
  input  logic              por_req,
  input  logic              lvr_req,
  input  logic              cm_fail,
  input  logic              cm_en,
  input  logic              selfclk_en,
  input  logic              wdt_timeout,
  input  logic [RATE_W-1:0] wdt_rate,
  output logic              cm_hit,
  output logic              wd_hit,
  output logic              seq_arst_n,
  output logic              flag_arst_n
);
  // qualified internal requests
  assign cm_hit = cm_fail && cm_en && !selfclk_en;
  assign wd_hit = wdt_timeout && (wdt_rate != '0);

  // sequencer is forced into reset by any internal source
  assign seq_arst_n  = !(por_req || lvr_req || cm_hit || wd_hit);
  // sticky flags only lose state on supply events
  assign flag_arst_n = !(por_req || lvr_req);
endmodule

// File: rtl/rstseq_shift.sv
module rstseq_shift #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_nxt;

  assign q_nxt[0] = clr ? RST_VAL : din;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    assign q_nxt[i] = clr ? RST_VAL : q[i-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= {STAGES{RST_VAL}};
    else         q <= q_nxt;
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags (
  input  logic clk,
  input  logic flag_arst_n,
  input  logic cm_hit,
  input  logic wd_hit,
  input  logic clr,
  output logic cm_pend,
  output logic wd_pend
);
  logic cm_nxt, wd_nxt;

  // a new event wins over a simultaneous clear
  always_comb begin
    cm_nxt = cm_hit ? 1'b1 : (clr ? 1'b0 : cm_pend);
    wd_nxt = wd_hit ? 1'b1 : (clr ? 1'b0 : wd_pend);
  end

  always_ff @(posedge clk or negedge flag_arst_n) begin
    if (!flag_arst_n) begin
      cm_pend <= 1'b0;
      wd_pend <= 1'b0;
    end else begin
      cm_pend <= cm_nxt;
      wd_pend <= wd_nxt;
    end
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int DRIVE_CYC  = 128,
  parameter int SETTLE_CYC = 64
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       go,
  input  logic       line_hi,
  input  logic       cm_pend,
  input  logic       wd_pend,
  output logic       pin_pd,
  output logic       run,
  output logic       restart,
  output logic       done,
  output logic [1:0] vec
);
  localparam int CNT_MAX = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_st_t          st, st_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             done_nxt;
  logic             vec_en;
  vec_t             vec_q, vec_nxt;

  always_comb begin
    st_nxt   = st;
    cnt_nxt  = cnt;
    done_nxt = 1'b0;
    vec_en   = 1'b0;
    restart  = 1'b0;
    vec_nxt  = pick_vec(line_hi, cm_pend, wd_pend);
    case (st)
      ST_DRIVE: begin
        if (go) begin
          if (cnt == DRIVE_LAST) begin
            st_nxt  = ST_SETTLE;
            cnt_nxt = '0;
          end else begin
            cnt_nxt = cnt + CNT_W'(1);
          end
        end
      end
      ST_SETTLE: begin
        if (cnt == SETTLE_LAST) begin
          st_nxt   = ST_RUN;
          cnt_nxt  = '0;
          done_nxt = 1'b1;
          vec_en   = 1'b1;
        end else begin
          cnt_nxt = cnt + CNT_W'(1);
        end
      end
      ST_RUN: begin
        if (!line_hi) begin
          st_nxt  = ST_DRIVE;
          cnt_nxt = '0;
          restart = 1'b1;
        end
      end
      default: begin
        st_nxt  = ST_DRIVE;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st   <= ST_DRIVE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      st   <= st_nxt;
      cnt  <= cnt_nxt;
      done <= done_nxt;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     vec_q <= VEC_BOOT;
    else if (vec_en) vec_q <= vec_nxt;
  end

  assign pin_pd = (st == ST_DRIVE);
  assign run    = (st == ST_RUN);
  assign vec    = vec_q;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int DRIVE_CYC   = 128,
  parameter int SETTLE_CYC  = 64,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_STAGES = 2,
  parameter int RATE_W      = 3
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              lvr_req,
  input  logic              cm_fail,
  input  logic              cm_en,
  input  logic              selfclk_en,
  input  logic              wdt_timeout,
  input  logic [RATE_W-1:0] wdt_rate,
  input  logic              rst_pin_in,
  input  logic              vec_ack,
  output logic              rst_pin_pd,
  output logic              core_rst_n,
  output logic              seq_done,
  output logic [1:0]        vec_code
);
  logic cm_hit, wd_hit, seq_arst_n, flag_arst_n;
  logic sync_out, go, line_hi, restart;
  logic cm_pend, wd_pend, flag_clr;

  rstseq_req #(.RATE_W(RATE_W)) u_req (
    .por_req(por_req), .lvr_req(lvr_req), .cm_fail(cm_fail), .cm_en(cm_en),
    .selfclk_en(selfclk_en), .wdt_timeout(wdt_timeout), .wdt_rate(wdt_rate),
    .cm_hit(cm_hit), .wd_hit(wd_hit), .seq_arst_n(seq_arst_n), .flag_arst_n(flag_arst_n)
  );

  // reset release: synchronizer then fixed pipeline
  rstseq_shift #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rel_sync (
    .clk(clk), .arst_n(seq_arst_n), .clr(restart), .din(1'b1), .dout(sync_out)
  );
  rstseq_shift #(.STAGES(PIPE_STAGES), .RST_VAL(1'b0)) u_rel_pipe (
    .clk(clk), .arst_n(seq_arst_n), .clr(restart), .din(sync_out), .dout(go)
  );

  // board reset line read-back
  rstseq_shift #(.STAGES(2), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .arst_n(seq_arst_n), .clr(1'b0), .din(rst_pin_in), .dout(line_hi)
  );

  assign flag_clr = vec_ack && core_rst_n;

  rstseq_flags u_flags (
    .clk(clk), .flag_arst_n(flag_arst_n), .cm_hit(cm_hit), .wd_hit(wd_hit),
    .clr(flag_clr), .cm_pend(cm_pend), .wd_pend(wd_pend)
  );

  rstseq_fsm #(.DRIVE_CYC(DRIVE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .arst_n(seq_arst_n), .go(go), .line_hi(line_hi),
    .cm_pend(cm_pend), .wd_pend(wd_pend), .pin_pd(rst_pin_pd), .run(core_rst_n),
    .restart(restart), .done(seq_done), .vec(vec_code)
  );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk,
  input logic       seq_arst_n,
  input logic       flag_arst_n,
  input logic       rst_pin_pd,
  input logic       core_rst_n,
  input logic       seq_done,
  input logic [1:0] vec_code,
  input logic       vec_ack,
  input logic       cm_pend,
  input logic       wd_pend
);
  // R1: while an internal request holds the sequencer, the line is pulled
  a_r1_entry_drives: assert property (@(posedge clk) disable iff (!flag_arst_n)
    !seq_arst_n |-> (rst_pin_pd && !core_rst_n));

  // R4: pull-down and released internal reset never coexist
  a_r4_drive_excl: assert property (@(posedge clk) disable iff (!seq_arst_n)
    rst_pin_pd |-> !core_rst_n);

  // R5: strobe lasts one cycle and coincides with release
  a_r5_done_single: assert property (@(posedge clk) disable iff (!seq_arst_n)
    seq_done |=> !seq_done);
  a_r5_done_release: assert property (@(posedge clk) disable iff (!seq_arst_n)
    seq_done |-> (core_rst_n && !$past(core_rst_n)));

  // R8: illegal class code never presented
  a_r8_code_legal: assert property (@(posedge clk) disable iff (!seq_arst_n)
    vec_code != 2'b11);

  // R9: accepted acknowledge empties both flags unless a new reset starts
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!flag_arst_n)
    (vec_ack && core_rst_n) |=> ((!cm_pend && !wd_pend) || !core_rst_n));

  // R11: class code held while running
  a_r11_vec_hold: assert property (@(posedge clk) disable iff (!seq_arst_n)
    (core_rst_n && !seq_done) |-> $stable(vec_code));
endmodule

bind rstseq_top rstseq_chk u_chk (
  .clk(clk), .seq_arst_n(seq_arst_n), .flag_arst_n(flag_arst_n),
  .rst_pin_pd(rst_pin_pd), .core_rst_n(core_rst_n), .seq_done(seq_done),
  .vec_code(vec_code), .vec_ack(vec_ack), .cm_pend(cm_pend), .wd_pend(wd_pend)
);

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
  logic       clk = 1'b0;
  logic       por_req = 1'b1, lvr_req = 1'b0, cm_fail = 1'b0, cm_en = 1'b0;
  logic       selfclk_en = 1'b0, wdt_timeout = 1'b0, vec_ack = 1'b0, ext_hold = 1'b0;
  logic [2:0] wdt_rate = 3'd0;
  logic       rst_pin_in, rst_pin_pd, core_rst_n, seq_done;
  logic [1:0] vec_code;
  int checks = 0, fails = 0;

  localparam int DRIVE_EDGES  = 132;
  localparam int SETTLE_EDGES = 64;

  always #2.5 clk = ~clk;

  // open-drain line: low if this block or an outside source pulls it
  assign rst_pin_in = !(rst_pin_pd || ext_hold);

  rstseq_top uut (
    .clk(clk), .por_req(por_req), .lvr_req(lvr_req), .cm_fail(cm_fail), .cm_en(cm_en),
    .selfclk_en(selfclk_en), .wdt_timeout(wdt_timeout), .wdt_rate(wdt_rate),
    .rst_pin_in(rst_pin_in), .vec_ack(vec_ack), .rst_pin_pd(rst_pin_pd),
    .core_rst_n(core_rst_n), .seq_done(seq_done), .vec_code(vec_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edge_s();
    @(posedge clk); #1;
  endtask

  // counts drive and settle edges, then checks strobe and class
  task automatic run_seq(input int exp_vec, input string tag);
    int n = 0;
    int m = 0;
    do begin edge_s(); n++; end while (rst_pin_pd && n < 1000);
    chk({"R4 drive edges ", tag}, n, DRIVE_EDGES);
    do begin edge_s(); m++; end while (!core_rst_n && m < 1000);
    chk({"R5 settle edges ", tag}, m, SETTLE_EDGES);
    chk({"R5 done strobe ", tag}, int'(seq_done), 1);
    chk({"R6/R7/R8 class ", tag}, int'(vec_code), exp_vec);
    edge_s();
    chk({"R5 strobe one cycle ", tag}, int'(seq_done), 0);
    chk({"R11 class held ", tag}, int'(vec_code), exp_vec);
  endtask

  task automatic wait_done();
    int k = 0;
    do begin edge_s(); k++; end while (!seq_done && k < 1000);
  endtask

  task automatic t_power_on();
    repeat (4) edge_s();
    chk("R1 por pin pd", int'(rst_pin_pd), 1);
    chk("R1 por core rst", int'(core_rst_n), 0);
    chk("R5 reset strobe", int'(seq_done), 0);
    chk("R8 reset class", int'(vec_code), 0);
    @(negedge clk); por_req = 1'b0;
    run_seq(0, "por");
  endtask

  task automatic t_lvr_async();
    @(negedge clk); #0.5 lvr_req = 1'b1; #1;
    chk("R1 async pin pd", int'(rst_pin_pd), 1);
    chk("R1 async core rst", int'(core_rst_n), 0);
    @(negedge clk); @(negedge clk); lvr_req = 1'b0;
    run_seq(0, "lvr");
  endtask

  task automatic t_cm_qualify();
    @(negedge clk); cm_en = 1'b0; cm_fail = 1'b1;
    repeat (3) edge_s();
    chk("R2 cm disabled", int'(rst_pin_pd), 0);
    @(negedge clk); cm_en = 1'b1; selfclk_en = 1'b1;
    repeat (3) edge_s();
    chk("R2 selfclk blocks", int'(core_rst_n), 1);
    @(negedge clk); selfclk_en = 1'b0; #1;
    chk("R2 cm qualified entry", int'(rst_pin_pd), 1);
    @(negedge clk); @(negedge clk); cm_fail = 1'b0;
    run_seq(1, "cm");
  endtask

  // outside pulse on the reset line, entry checked at synchronizer depth
  task automatic t_ext_pulse(input int exp_vec, input string tag);
    @(negedge clk); ext_hold = 1'b1;
    edge_s(); edge_s();
    chk({"R10 not yet entered ", tag}, int'(rst_pin_pd), 0);
    edge_s();
    chk({"R10 entered ", tag}, int'(rst_pin_pd), 1);
    @(negedge clk); ext_hold = 1'b0;
    run_seq(exp_vec, tag);
  endtask

  task automatic t_ack();
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
    t_ext_pulse(0, "R9 ack cleared");
  endtask

  task automatic t_wdog();
    @(negedge clk); wdt_rate = 3'd0; wdt_timeout = 1'b1;
    repeat (3) edge_s();
    chk("R3 rate zero no effect pd", int'(rst_pin_pd), 0);
    chk("R3 rate zero no effect core", int'(core_rst_n), 1);
    @(negedge clk); wdt_rate = 3'd5; #1;
    chk("R3 rate nonzero entry", int'(rst_pin_pd), 1);
    @(negedge clk); @(negedge clk); wdt_timeout = 1'b0;
    run_seq(2, "wd");
  endtask

  task automatic t_cm_over_wd();
    @(negedge clk); cm_fail = 1'b1;
    @(negedge clk); @(negedge clk); cm_fail = 1'b0;
    run_seq(1, "R7 both pending");
  endtask

  task automatic t_line_held();
    @(negedge clk); ext_hold = 1'b1;
    wait_done();
    chk("R6 line low class", int'(vec_code), 0);
    edge_s();
    chk("R10 re-entry while held", int'(rst_pin_pd), 1);
    @(negedge clk); ext_hold = 1'b0;
    wait_done();
    chk("R9 flags survive", int'(vec_code), 1);
  endtask

  task automatic t_ack_during_seq();
    @(negedge clk); vec_ack = 1'b1; cm_fail = 1'b1;
    @(negedge clk); @(negedge clk); cm_fail = 1'b0;
    repeat (100) @(negedge clk);
    vec_ack = 1'b0;
    wait_done();
    chk("R9 ack in sequence ignored", int'(vec_code), 1);
  endtask

  task automatic t_por_clears();
    @(negedge clk); por_req = 1'b1;
    @(negedge clk); @(negedge clk); por_req = 1'b0;
    run_seq(0, "R9 por clears");
  endtask

  initial begin
    t_power_on();
    t_lvr_async();
    t_cm_qualify();
    t_ext_pulse(1, "R9 persist");
    t_ack();
    t_wdog();
    t_cm_over_wd();
    t_line_held();
    t_ack_during_seq();
    t_por_clears();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 60000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule